// File: doc/BRIEF.md
# Arithmetic Logic Unit with Word-Extending Shifter

This block is an N-bit arithmetic and logic stage feeding a one-bit shifter, with an auxiliary word register (the M register) next to it. Two operands and a 3-bit function code select one of eight results. The result then passes through a shifter that either leaves it unchanged or moves it one place left or right. Two of the shift modes treat the concatenation of the result and the M register as a single 2N-bit word, so that a bit can cross between them.

The shifted result is presented combinationally on the data output. The M register is clocked. It can capture the shifted result, take its half of a 2N-bit shift, or hold its value. A surrounding datapath chooses the operands and decides where the result goes.

Top module: `alu_shift_unit`

## Requirements
- R1: Function code 3'b000 yields operand A and 3'b001 yields operand B.
- R2: Function code 3'b010 yields all zeros and 3'b011 yields all ones.
- R3: Function code 3'b100 yields A+B and 3'b101 yields A-B, both wrapping modulo 2^N, with no flags.
- R4: Function code 3'b110 yields bitwise A AND B and 3'b111 yields bitwise A OR B.
- R5: With shift enable low, the output equals the function result unshifted.
- R6: With shift enable high, shift code 2'b00 shifts the result left by one and 2'b01 shifts it right by one. In both cases the vacated bit is filled with zero.
- R7: Shift code 2'b10 shifts {result, M} left by one as a 2N-bit word. The output becomes {result[N-2:0], M[N-1]}, and M becomes {M[N-2:0], 0} at the next clock edge unless a load is requested.
- R8: Shift code 2'b11 shifts {result, M} right by one as a 2N-bit word. The output becomes {0, result[N-1:1]}, and M becomes {result[0], M[N-1:1]} at the next clock edge unless a load is requested.
- R9: With the load strobe high, M captures the data output at the clock edge. This takes priority over any M update from the shifter.
- R10: M keeps its value when the load strobe is low and no shift through M is enabled. This includes shift codes 2'b00 and 2'b01.
- R11: A synchronous active-low reset clears M to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_i | input | N | Operand A |
| b_i | input | N | Operand B |
| op_i | input | 3 | Function code |
| shift_en_i | input | 1 | Enables the shifter |
| shift_code_i | input | 2 | Shift direction and whether M takes part |
| ldm_i | input | 1 | Load strobe for M |
| y_o | output | N | Shifted result |
| m_o | output | N | M register contents |

## Verification
The load strobe and a shift through M can both ask to change M in the same cycle. The bench provokes this in directed steps, with load high and shift code 2'b10 or 2'b11 enabled, and it also reaches it often in its random phase. In each such cycle the reference model expects M to hold the shifted output, not the shifted M half. The bench compares M on the following clock, so a design that lets the shifter win is caught.

// File: rtl/alu_shift_pkg.sv
// Shared encodings for the ALU and shift stage.
// Assumes: the function and shift code values are fixed by the surrounding datapath.
package alu_shift_pkg;

    typedef enum logic [2:0] {
        OP_PASS_A = 3'b000,
        OP_PASS_B = 3'b001,
        OP_ZERO   = 3'b010,
        OP_ONES   = 3'b011,
        OP_ADD    = 3'b100,
        OP_SUB    = 3'b101,
        OP_AND    = 3'b110,
        OP_OR     = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT    = 2'b00,
        SH_RIGHT   = 2'b01,
        SH_LEFT_M  = 2'b10,
        SH_RIGHT_M = 2'b11
    } shift_code_e;

endpackage

// File: rtl/alu_core.sv
// Combinational N-bit function unit: pass, constants, wrap-around add/sub, AND, OR.
// Assumes: N >= 2; no carry or status flags are needed downstream.
module alu_core
    import alu_shift_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic [2:0]   op_i,
    output logic [N-1:0] res_o
);

    // Select the function result from the decoded code.
    always_comb begin
        case (alu_op_e'(op_i))
            OP_PASS_A: res_o = a_i;
            OP_PASS_B: res_o = b_i;
            OP_ZERO:   res_o = '0;
            OP_ONES:   res_o = '1;
            OP_ADD:    res_o = a_i + b_i;
            OP_SUB:    res_o = a_i - b_i;
            OP_AND:    res_o = a_i & b_i;
            OP_OR:     res_o = a_i | b_i;
            default:   res_o = '0;
        endcase
    end

endmodule

// File: rtl/shift_stage.sv
// One-place shifter. It can extend the word with the M register into a 2N-bit value.
// Assumes: N >= 2; the M update it proposes is applied by the register owner.
module shift_stage
    import alu_shift_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] res_i,
    input  logic [N-1:0] m_i,
    input  logic         en_i,
    input  logic [1:0]   code_i,
    output logic [N-1:0] y_o,
    output logic [N-1:0] m_next_o,
    output logic         m_upd_o
);

    // Produce the shifted result and, for modes through M, the new M half.
    always_comb begin
        y_o      = res_i;
        m_next_o = m_i;
        m_upd_o  = 1'b0;
        if (en_i) begin
            case (shift_code_e'(code_i))
                SH_LEFT:   y_o = {res_i[N-2:0], 1'b0};
                SH_RIGHT:  y_o = {1'b0, res_i[N-1:1]};
                SH_LEFT_M: begin
                    y_o      = {res_i[N-2:0], m_i[N-1]};
                    m_next_o = {m_i[N-2:0], 1'b0};
                    m_upd_o  = 1'b1;
                end
                SH_RIGHT_M: begin
                    y_o      = {1'b0, res_i[N-1:1]};
                    m_next_o = {res_i[0], m_i[N-1:1]};
                    m_upd_o  = 1'b1;
                end
                default: y_o = res_i;
            endcase
        end
    end

endmodule

// File: rtl/m_register.sv
// The M register. Load has priority over the shifter update, and reset clears it.
// Assumes: synchronous active-low reset.
module m_register #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] load_val_i,
    input  logic         shift_upd_i,
    input  logic [N-1:0] shift_val_i,
    output logic [N-1:0] q_o
);

    // Update M: reset, then load, then shift, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (load_i)
            q_o <= load_val_i;
        else if (shift_upd_i)
            q_o <= shift_val_i;
    end

endmodule

// File: rtl/alu_shift_unit.sv
// Top: function unit -> shifter -> output, with the M register closing the loop.
// Assumes: operand selection and result routing happen outside this block.
module alu_shift_unit #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic [2:0]   op_i,
    input  logic         shift_en_i,
    input  logic [1:0]   shift_code_i,
    input  logic         ldm_i,
    output logic [N-1:0] y_o,
    output logic [N-1:0] m_o
);

    logic [N-1:0] alu_res;
    logic [N-1:0] m_shifted;
    logic         m_shift_upd;

    alu_core #(.N(N)) u_alu (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op_i),
        .res_o (alu_res)
    );

    shift_stage #(.N(N)) u_shift (
        .res_i    (alu_res),
        .m_i      (m_o),
        .en_i     (shift_en_i),
        .code_i   (shift_code_i),
        .y_o      (y_o),
        .m_next_o (m_shifted),
        .m_upd_o  (m_shift_upd)
    );

    m_register #(.N(N)) u_mreg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (ldm_i),
        .load_val_i  (y_o),
        .shift_upd_i (m_shift_upd),
        .shift_val_i (m_shifted),
        .q_o         (m_o)
    );

endmodule

// File: rtl/alu_shift_unit_chk.sv
// Port-level temporal checks for alu_shift_unit.
module alu_shift_unit_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         shift_en_i,
    input logic [1:0]   shift_code_i,
    input logic         ldm_i,
    input logic [N-1:0] y_o,
    input logic [N-1:0] m_o
);

    // R9
    ldm_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ldm_i) |-> m_o == $past(y_o));

    // R7
    left_m_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(ldm_i) && $past(shift_en_i) && $past(shift_code_i) == 2'b10
        |-> m_o == {$past(m_o[N-2:0]), 1'b0});

    // R7
    left_m_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i && shift_code_i == 2'b10 |-> y_o[0] == m_o[N-1]);

    // R8
    right_m_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(ldm_i) && $past(shift_en_i) && $past(shift_code_i) == 2'b11
        |-> m_o[N-2:0] == $past(m_o[N-1:1]));

    // R6
    right_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i && shift_code_i[0] |-> !y_o[N-1]);

    // R10
    m_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(ldm_i) && !($past(shift_en_i) && $past(shift_code_i[1]))
        |-> $stable(m_o));

endmodule

bind alu_shift_unit alu_shift_unit_chk #(.N(N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_en_i   (shift_en_i),
    .shift_code_i (shift_code_i),
    .ldm_i        (ldm_i),
    .y_o          (y_o),
    .m_o          (m_o)
);

// File: tb/alu_shift_unit_bench.sv
module alu_shift_unit_bench;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] a_i = '0, b_i = '0;
    logic [2:0]   op_i = '0;
    logic         shift_en_i = 1'b0;
    logic [1:0]   shift_code_i = '0;
    logic         ldm_i = 1'b0;
    logic [N-1:0] y_o, m_o;

    int total = 0;
    int bad = 0;
    logic [N-1:0] m_model = '0;

    always #4 clk = ~clk;

    alu_shift_unit #(.N(N)) u_alu_shift_unit (
        .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .op_i(op_i),
        .shift_en_i(shift_en_i), .shift_code_i(shift_code_i), .ldm_i(ldm_i),
        .y_o(y_o), .m_o(m_o)
    );

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive, check y, model the M update, then check M after the edge.
    task automatic step(int a, int b, int op, bit se, int sc, bit ld, bit rst);
        int r, yv, mv;
        logic [2*N-1:0] w;
        string ytag, mtag;
        int mask;
        mask = (1 << N) - 1;
        @(negedge clk);
        a_i = a[N-1:0]; b_i = b[N-1:0]; op_i = op[2:0];
        shift_en_i = se; shift_code_i = sc[1:0]; ldm_i = ld; rst_n = !rst;
        #1;
        case (op & 7)
            0: r = a & mask;
            1: r = b & mask;
            2: r = 0;
            3: r = mask;
            4: r = (a + b) & mask;
            5: r = (a - b) & mask;
            6: r = a & b & mask;
            default: r = (a | b) & mask;
        endcase
        mv = int'(m_model);
        yv = r;
        case ((op & 7) >> 1)
            0: ytag = (op & 1) ? "R1_passB" : "R1_passA";
            1: ytag = "R2_const";
            2: ytag = "R3_addsub";
            default: ytag = "R4_logic";
        endcase
        if (!se) ytag = {ytag, "/R5_noshift"};
        else begin
            w = {r[N-1:0], m_model};
            case (sc & 3)
                0: begin yv = (r << 1) & mask; ytag = "R6_left"; end
                1: begin yv = r >> 1; ytag = "R6_right"; end
                2: begin w = w << 1; yv = int'(w[2*N-1:N]); mv = int'(w[N-1:0]); ytag = "R7_leftM"; end
                default: begin w = w >> 1; yv = int'(w[2*N-1:N]); mv = int'(w[N-1:0]); ytag = "R8_rightM"; end
            endcase
        end
        check(ytag, y_o, yv[N-1:0]);
        if (rst) begin mv = 0; mtag = "R11_reset"; end
        else if (ld) begin mv = yv; mtag = "R9_load"; end
        else if (se && sc >= 2) mtag = (sc == 2) ? "R7_Mleft" : "R8_Mright";
        else begin mv = int'(m_model); mtag = "R10_hold"; end
        @(posedge clk);
        #1;
        m_model = mv[N-1:0];
        check(mtag, m_o, m_model);
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        total++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(0, 0, 0, 0, 0, 1, 1);             // R11 reset clears M
        step(8'h5A, 8'hC3, 0, 0, 0, 0, 0);     // R1
        step(8'h5A, 8'hC3, 1, 0, 0, 0, 0);     // R1
        step(8'h5A, 8'hC3, 2, 0, 0, 0, 0);     // R2
        step(8'h5A, 8'hC3, 3, 0, 0, 1, 0);     // R2, R9 load ones
        step(8'hF0, 8'h20, 4, 0, 0, 0, 0);     // R3 wrap
        step(8'h10, 8'h20, 5, 0, 0, 0, 0);     // R3 borrow wrap
        step(8'hCC, 8'hAA, 6, 0, 0, 0, 0);     // R4
        step(8'hCC, 8'hAA, 7, 0, 0, 0, 0);     // R4
        step(8'h81, 0, 0, 1, 0, 0, 0);         // R6 left, R10 hold
        step(8'h81, 0, 0, 1, 1, 0, 0);         // R6 right, R10 hold
        step(8'h01, 0, 0, 1, 2, 0, 0);         // R7 with M=ff
        step(8'h81, 0, 0, 1, 3, 0, 0);         // R8
        step(8'h81, 0, 0, 1, 3, 1, 0);         // R9 wins over R8
        step(8'h40, 0, 0, 1, 2, 1, 0);         // R9 wins over R7
        step(0, 0, 3, 0, 0, 0, 1);             // R11 mid-run reset
        for (int i = 0; i < 2000; i++)
            step(int'($urandom), int'($urandom), int'($urandom_range(0, 7)),
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 bit'($urandom_range(0, 2) == 0), bit'($urandom_range(0, 60) == 0));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule